// File: doc/BRIEF.md
# Burst Word Address Sequencer for a Parallel-Bus Memory Target

This block sits inside the target side of a parallel PCI-style bus. When the address phase is captured, it latches the start address, the address-space type, the configured cache line size and a mask of the burst orders the target supports. It then produces the byte address of the current data word. Each time a word is transferred, `adv_i` moves the sequence to the next word. In memory space the two lowest address bits select the burst order.

The block also raises `term_o` when the current word must be the last one of the burst. This happens when the requested order cannot be served: the order is reserved, the order is outside the capability mask, or the cache line size has an unsupported value. With the `COHERENT` parameter set, it also happens when the next word would fall in a different cache line. The target state machine reads `term_o` and disconnects after the word that is in flight. Bus handshake decoding and data storage belong to other blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0 and `term_o` is 0. In the cycle after `start_i`, `addr_o` equals `{addr_i[31:2],2'b00}` as it was at the start edge.
- R2: In memory space (`space_i`=00), order code `addr_i[1:0]`=00 is linear order. Each `adv_i` adds 4 to `addr_o`, for example 0x0C, 0x10, 0x14, 0x18, 0x1C.
- R3: Order code 11 is toggle order. The word offset within the line is the start offset XOR (count mod line words). After a full line has been transferred, the line index increments. With 4-word lines, a start at 0x0C gives 0x0C, 0x08, 0x04, 0x00, 0x1C, 0x18.
- R4: Order code 10 is wrap order. The word offset is (start offset + count) mod line words, and the line steps the same way as in R3. With 4-word lines, a start at 0x0C gives 0x0C, 0x00, 0x04, 0x08, 0x1C, 0x10.
- R5: Order code 01 is reserved. It drives `term_o`=1 from the first word, and the address follows linear order.
- R6: In I/O space (`space_i`=01) and configuration space (`space_i`=10), the order is always linear. The address starts at `{addr_i[31:2],2'b00}`. The order code, `cls_i` and `cap_i` never assert `term_o`.
- R7: In memory space, `cap_i[code]`=0 for the requested order code asserts `term_o` from the first word.
- R8: `cls_i` gives the cache line length in words. Only 4, 8 and 16 are supported. In memory space, any other value asserts `term_o` from the first word.
- R9: With `COHERENT`=1, in memory space, `term_o` is 1 on the last word before a line change. In linear order this is a word whose offset in its line equals line words − 1. In toggle or wrap order it is the count at which (count mod line words) equals line words − 1. With `COHERENT`=0, these cases do not assert `term_o`.
- R10: While `adv_i` is low, `addr_o` and `term_o` hold their values. When `start_i` and `adv_i` are high together, `start_i` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Address phase strobe; latches all set-up inputs |
| addr_i | input | AW | Address from the address phase; bits [1:0] carry the order code in memory space |
| space_i | input | 2 | Address space: 00 memory, 01 I/O, 10 configuration |
| cls_i | input | CLS_W | Configured cache line size in words |
| cap_i | input | 4 | Supported order mask, indexed by order code |
| adv_i | input | 1 | A data word was transferred |
| addr_o | output | AW | Byte address of the current word |
| term_o | output | 1 | Current word must be the last of the burst |

## Verification
Several properties are checked on every cycle by assertions:
- The start address is loaded in the cycle after `start_i`.
- Each linear step adds exactly 4.
- The address and the termination flag hold while there is no advance.
- A reserved order code always terminates.
- In non-memory spaces, `term_o` stays low.
- In toggle and wrap order, the line index does not change within an in-line sequence.

The exact toggle and wrap address sequences, the line stepping after a complete line, the capability and line-size fallbacks, and the coherent boundary stop can only be shown by the bench. Its scenarios compare both parameter variants against a behavioural model on every clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic [1:0] {
    ORD_LIN  = 2'b00,
    ORD_RSVD = 2'b01,
    ORD_WRAP = 2'b10,
    ORD_TGL  = 2'b11
  } ord_e;

  localparam logic [1:0] SP_MEM = 2'b00;
  localparam logic [1:0] SP_IO  = 2'b01;
  localparam logic [1:0] SP_CFG = 2'b10;
endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
#(
  parameter int CLS_W = 8,
  parameter int MW    = 4
) (
  input  logic [1:0]       space_i,
  input  logic [1:0]       code_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [3:0]       cap_i,
  output ord_e             ord_o,
  output logic [MW-1:0]    mask_o,
  output logic             mem_o,
  output logic             single_o
);
  logic cls_ok;

  always_comb begin
    mem_o  = (space_i == SP_MEM);
    cls_ok = 1'b0;
    mask_o = MW'(3);
    // supported line sizes: powers of two from 4 words up to 2**MW
    for (int i = 2; i <= MW; i++) begin
      if (cls_i == CLS_W'(1 << i)) begin
        cls_ok = 1'b1;
        mask_o = MW'((1 << i) - 1);
      end
    end
    ord_o    = mem_o ? ord_e'(code_i) : ORD_LIN;
    single_o = mem_o && ((code_i == ORD_RSVD) || !cap_i[code_i] || !cls_ok);
  end
endmodule

// File: rtl/bseq_gen.sv
module bseq_gen
  import bseq_pkg::*;
#(
  parameter int WW = 30,
  parameter int MW = 4
) (
  input  logic [WW-1:0] base_i,
  input  logic [WW-1:0] cnt_i,
  input  ord_e          ord_i,
  input  logic [MW-1:0] mask_i,
  output logic [WW-1:0] waddr_o,
  output logic          line_end_o
);
  logic [WW-1:0] m, hi, lin;

  always_comb begin
    m   = WW'(mask_i);
    hi  = (base_i & ~m) + (cnt_i & ~m);
    lin = base_i + cnt_i;
    unique case (ord_i)
      ORD_TGL:  waddr_o = hi | ((base_i ^ cnt_i) & m);
      ORD_WRAP: waddr_o = hi | (lin & m);
      default:  waddr_o = lin;
    endcase
    // linear leaves the line at a physical boundary, the others after L words
    line_end_o = (ord_i == ORD_LIN) ? ((lin & m) == m) : ((cnt_i & m) == m);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CLS_W    = 8,
  parameter int MAX_CLS  = 16,
  parameter int COHERENT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [1:0]       space_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic [3:0]       cap_i,
  input  logic             adv_i,
  output logic [AW-1:0]    addr_o,
  output logic             term_o
);
  localparam int   WW  = AW - 2;
  localparam int   MW  = $clog2(MAX_CLS);
  localparam logic COH = (COHERENT != 0);

  ord_e          ord_d, ord_q;
  logic [MW-1:0] mask_d, mask_q;
  logic          mem_d, mem_q, single_d, single_q, active_q;
  logic [WW-1:0] base_q, cnt_q, waddr, line_w;
  logic          line_end;

  bseq_decode #(.CLS_W(CLS_W), .MW(MW)) i_decode (
    .space_i (space_i),
    .code_i  (addr_i[1:0]),
    .cls_i   (cls_i),
    .cap_i   (cap_i),
    .ord_o   (ord_d),
    .mask_o  (mask_d),
    .mem_o   (mem_d),
    .single_o(single_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      ord_q    <= ORD_LIN;
      mask_q   <= MW'(3);
      mem_q    <= 1'b0;
      single_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      base_q   <= addr_i[AW-1:2];
      cnt_q    <= '0;
      ord_q    <= ord_d;
      mask_q   <= mask_d;
      mem_q    <= mem_d;
      single_q <= single_d;
    end else if (adv_i && active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  bseq_gen #(.WW(WW), .MW(MW)) i_gen (
    .base_i    (base_q),
    .cnt_i     (cnt_q),
    .ord_i     (ord_q),
    .mask_i    (mask_q),
    .waddr_o   (waddr),
    .line_end_o(line_end)
  );

  assign addr_o = {waddr, 2'b00};
  assign term_o = active_q & (single_q | (COH & mem_q & line_end));
  assign line_w = waddr & ~WW'(mask_q);

  // R1
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> addr_o == {$past(addr_i[AW-1:2]), 2'b00});

  // R2
  lin_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !start_i && adv_i && ord_q == ORD_LIN |=> addr_o == $past(addr_o) + AW'(4));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !adv_i |=> $stable(addr_o) && $stable(term_o));

  // R5
  rsvd_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && mem_q && ord_q == ORD_RSVD |-> term_o);

  // R6
  io_noterm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !mem_q |-> !term_o);

  // R3 R4
  line_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !start_i && adv_i && (ord_q == ORD_TGL || ord_q == ORD_WRAP)
      && ((cnt_q & WW'(mask_q)) != WW'(mask_q)) |=> $stable(line_w));
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  space = 2'b00;
  logic [7:0]  cls = 8'd4;
  logic [3:0]  cap = 4'hF;
  logic        adv = 1'b0;
  logic [31:0] a_o, ac_o;
  logic        t_o, tc_o;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string req = "R1";

  // model state
  bit       m_act = 0;
  longint   m_base = 0, m_cnt = 0;
  int       m_code = 0, m_space = 0, m_cls = 4;
  bit [3:0] m_cap = 4'hF;

  always #5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .space_i(space),
    .cls_i(cls), .cap_i(cap), .adv_i(adv), .addr_o(a_o), .term_o(t_o));

  burst_addr_seq #(.COHERENT(1)) i_burst_addr_seq_coh (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .space_i(space),
    .cls_i(cls), .cap_i(cap), .adv_i(adv), .addr_o(ac_o), .term_o(tc_o));

  function automatic bit cls_good();
    return m_cls == 4 || m_cls == 8 || m_cls == 16;
  endfunction

  function automatic longint line_words();
    return cls_good() ? longint'(m_cls) : 64'd4;
  endfunction

  function automatic bit is_mem();
    return m_space == 0;
  endfunction

  function automatic logic [31:0] exp_addr();
    longint l = line_words();
    longint w;
    if (!m_act) return 32'h0;
    if (is_mem() && m_code == 3)
      w = (m_base / l + m_cnt / l) * l + ((m_base % l) ^ (m_cnt % l));
    else if (is_mem() && m_code == 2)
      w = (m_base / l + m_cnt / l) * l + ((m_base % l + m_cnt % l) % l);
    else
      w = m_base + m_cnt;
    w = w % (64'd1 << 30);
    return 32'(w * 4);
  endfunction

  function automatic bit exp_term(bit coh);
    longint l = line_words();
    bit single, lend;
    if (!m_act) return 1'b0;
    single = is_mem() && (m_code == 1 || !m_cap[m_code] || !cls_good());
    lend = (m_code == 0) ? (((m_base + m_cnt) % l) == l - 1) : ((m_cnt % l) == l - 1);
    return single || (coh && is_mem() && lend);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic compare();
    chk(req, a_o, exp_addr());
    chk(req, ac_o, exp_addr());
    chk(req, 32'(t_o), 32'(exp_term(1'b0)));
    chk("R9", 32'(tc_o), 32'(exp_term(1'b1)));
  endtask

  task automatic step(bit st, logic [31:0] a, bit ad);
    start = st; addr = a; adv = ad;
    @(posedge clk);
    if (st) begin
      m_act = 1; m_base = longint'(a >> 2); m_cnt = 0; m_code = int'(a[1:0]);
      m_space = int'(space); m_cls = int'(cls); m_cap = cap;
    end else if (ad && m_act) m_cnt++;
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
    compare();
  endtask

  task automatic burst(string r, logic [1:0] sp, logic [7:0] cl, logic [3:0] cp,
                       logic [31:0] a, int n);
    req = r; space = sp; cls = cl; cap = cp;
    step(1'b1, a, 1'b0);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    // R2 linear, crosses lines
    burst("R2", 2'b00, 8'd4, 4'hF, 32'h0000_000C, 5);
    burst("R2", 2'b00, 8'd8, 4'hF, 32'h0000_0100, 9);
    // R3 toggle
    burst("R3", 2'b00, 8'd4, 4'hF, 32'h0000_000F, 6);
    burst("R3", 2'b00, 8'd8, 4'hF, 32'h0000_0217, 10);
    burst("R3", 2'b00, 8'd16, 4'hF, 32'h0000_1027, 18);
    // R4 wrap
    burst("R4", 2'b00, 8'd4, 4'hF, 32'h0000_000E, 6);
    burst("R4", 2'b00, 8'd16, 4'hF, 32'h0000_303A, 18);
    // R10 hold and start priority
    burst("R10", 2'b00, 8'd8, 4'hF, 32'h0000_0053, 2);
    for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 1'b0);
    step(1'b0, 32'h0, 1'b1);
    step(1'b1, 32'h0000_0400, 1'b1);
    step(1'b0, 32'h0, 1'b0);
    // R5 reserved
    burst("R5", 2'b00, 8'd4, 4'hF, 32'h0000_0041, 3);
    // R6 io and configuration
    burst("R6", 2'b01, 8'd6, 4'h0, 32'h0000_000F, 6);
    burst("R6", 2'b10, 8'd4, 4'h0, 32'h0000_0082, 4);
    // R7 capability mask
    burst("R7", 2'b00, 8'd4, 4'b0101, 32'h0000_0023, 2);
    burst("R7", 2'b00, 8'd4, 4'b1001, 32'h0000_0022, 2);
    burst("R7", 2'b00, 8'd4, 4'b1100, 32'h0000_0020, 2);
    // R8 line size fallback
    burst("R8", 2'b00, 8'd6, 4'hF, 32'h0000_0033, 2);
    burst("R8", 2'b00, 8'd0, 4'hF, 32'h0000_0030, 2);
    burst("R8", 2'b00, 8'd32, 4'hF, 32'h0000_0032, 2);
    // R9 coherent stop, top of address space
    burst("R9", 2'b00, 8'd8, 4'hF, 32'hFFFF_FFF0, 4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule